// File: doc/BRIEF.md
# I2C Command-Word Target

This block is the serial front end of a small two-channel converter. It watches the I2C clock and data lines with a fast system clock and pulls the data line low through an open-drain enable. It answers one 7-bit address. The upper five bits of that address are fixed, and the lower two come from strap inputs.

Once the address matches, the block collects 24-bit command words. Each word is a command byte followed by a high and a low data byte. The bytes are held in a staging register until the word is complete. During the acknowledge period of the low byte, the block hands the whole word to an external register file as a single one-cycle write strobe. Any number of words may follow one another inside a single START-to-STOP frame.

For readback, the master writes a command byte and then issues a repeated START and a read address. The block then returns the selected 16-bit register, high byte first. Only code-register commands (upper command nibble zero) read real data. Every other byte read back is all ones.

Top module: `i2c_cmd_target`

## Requirements
- R1: The block acknowledges (drives SDA low during the ninth clock) only an address byte whose upper seven bits equal 0b00011 followed by the two strap bits. Bit 0 of the address byte is the direction: 0 for write, 1 for read. On a mismatch, SDA stays released and no write strobe occurs until the next START.
- R2: In a write frame, every byte received after a matched address is acknowledged by SDA being low during its ninth clock.
- R3: After the address, the bytes form words in the order command, data high, data low. When the low byte completes, `wr_en` pulses high for exactly one cycle while the block is driving its acknowledge. At that moment `wr_cmd` holds the command byte and `wr_data` holds {high, low}. `wr_cmd` and `wr_data` change only in a cycle in which `wr_en` is high.
- R4: Any number of complete words in one frame each produce their own strobe, in arrival order.
- R5: A word left incomplete when STOP arrives produces no strobe.
- R6: A read frame that follows a command byte with upper nibble 0000 puts the lower command nibble on `rd_chan`. It then returns `rd_data[15:8]` and then `rd_data[7:0]`, most significant bit first.
- R7: Read bytes beyond the two data bytes are 0xFF. Both data bytes are also 0xFF when the selected command has a nonzero upper nibble.
- R8: When the master answers a read byte with NACK (SDA high on the ninth clock), the block releases SDA and drives nothing until the next START.
- R9: A START or repeated START at any point returns the block to address reception and releases SDA. STOP releases SDA and returns to idle.
- R10: The block changes `sda_oe` only while SCL is low.
- R11: After reset, `sda_oe` and `wr_en` are 0 and `wr_cmd`/`wr_data` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the pin |
| sda_i | input | 1 | I2C data line as seen on the pin |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| strap_i | input | 2 | Pin-strapped low address bits |
| wr_en | output | 1 | One-cycle execute strobe for a complete word |
| wr_cmd | output | 8 | Command byte of the executed word |
| wr_data | output | 16 | Data of the executed word, high byte in bits 15:8 |
| rd_chan | output | CHAN_W | Channel selected for readback |
| rd_data | input | 16 | Register-file contents for `rd_chan` |

## Verification
On every cycle, the checker confirms four properties. The write strobe lasts one cycle and lines up with the block's own acknowledge. The write outputs move only with the strobe. The pad enable changes only after SCL has been low. START and STOP both release the line. The bench has to show everything tied to frame content: address filtering against the straps, back-to-back words, a discarded partial word, a restart in the middle of a byte, byte order and 0xFF padding on readback, and the silence after a NACK. It does this with its own master model and its own register-file model.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    localparam int CMD_W      = 8;
    localparam int DATA_W     = 16;
    localparam int WORD_BYTES = 3;
    localparam int IDX_W      = $clog2(WORD_BYTES);
    localparam int BIT_W      = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WRITE,
        ST_WRITE_ACK,
        ST_READ,
        ST_READ_ACK,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e          st;
        logic [BIT_W-1:0]    bit_cnt;
        logic                byte_done;
        logic [7:0]          shreg;
        logic [IDX_W-1:0]    widx;
        logic [CMD_W-1:0]    cmd_stage;
        logic [7:0]          hi_stage;
        logic [1:0]          ridx;
        logic [CMD_W-1:0]    rd_cmd;
        logic [7:0]          tx;
        logic                oe;
        logic                wen;
        logic [CMD_W-1:0]    wcmd;
        logic [DATA_W-1:0]   wdata;
    } frame_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] scl_q, scl_d;
    logic [STAGES-1:0] sda_q, sda_d;
    logic              scl_p_q, sda_p_q;
    logic              scl_s;

    always_comb begin
        scl_d = {scl_q[STAGES-2:0], scl_i};
        sda_d = {sda_q[STAGES-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q   <= '1;
            sda_q   <= '1;
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_q   <= scl_d;
            sda_q   <= sda_d;
            scl_p_q <= scl_q[LAST];
            sda_p_q <= sda_q[LAST];
        end
    end

    assign scl_s     = scl_q[LAST];
    assign sda_s     = sda_q[LAST];
    assign scl_rise  = scl_s & ~scl_p_q;
    assign scl_fall  = ~scl_s & scl_p_q;
    assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;

endmodule

// File: rtl/i2c_frame_ctrl.sv
module i2c_frame_ctrl
    import i2c_cmd_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b00011,
    parameter int         CHAN_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        strap_i,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [CMD_W-1:0]  wr_cmd,
    output logic [DATA_W-1:0] wr_data,
    output logic [CHAN_W-1:0] rd_chan
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_BYTES - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = '1;

    frame_t q, d;

    function automatic logic [7:0] pick_byte(input logic [1:0] idx,
                                             input logic [CMD_W-1:0] cmd,
                                             input logic [DATA_W-1:0] data);
        if (cmd[7:4] != 4'h0) return 8'hFF;
        case (idx)
            2'd0:    return data[15:8];
            2'd1:    return data[7:0];
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [1:0] next_ridx(input logic [1:0] idx);
        return (idx == 2'd2) ? idx : idx + 2'd1;
    endfunction

    always_comb begin
        d     = q;
        d.wen = 1'b0;
        if (start_det) begin
            d.st        = ST_ADDR;
            d.bit_cnt   = '0;
            d.byte_done = 1'b0;
            d.oe        = 1'b0;
            d.widx      = '0;
            d.ridx      = '0;
        end else if (stop_det) begin
            d.st        = ST_IDLE;
            d.oe        = 1'b0;
            d.widx      = '0;
            d.byte_done = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_WRITE: begin
                    if (scl_rise && !q.byte_done) begin
                        d.shreg   = {q.shreg[6:0], sda_s};
                        d.bit_cnt = q.bit_cnt + 1'b1;
                        if (q.bit_cnt == BIT_LAST) d.byte_done = 1'b1;
                    end else if (scl_fall && q.byte_done) begin
                        d.byte_done = 1'b0;
                        if (q.st == ST_ADDR) begin
                            if (q.shreg[7:1] == {ADDR_PREFIX, strap_i}) begin
                                d.st = ST_ADDR_ACK;
                                d.oe = 1'b1;
                            end else begin
                                d.st = ST_SKIP;
                            end
                        end else begin
                            d.st = ST_WRITE_ACK;
                            d.oe = 1'b1;
                            if (q.widx == IDX_LAST) begin
                                d.wen   = 1'b1;
                                d.wcmd  = q.cmd_stage;
                                d.wdata = {q.hi_stage, q.shreg};
                                d.widx  = '0;
                            end else begin
                                if (q.widx == '0) begin
                                    d.cmd_stage = q.shreg;
                                    d.rd_cmd    = q.shreg;
                                end else begin
                                    d.hi_stage = q.shreg;
                                end
                                d.widx = q.widx + 1'b1;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.bit_cnt = '0;
                        if (q.shreg[0]) begin
                            d.st   = ST_READ;
                            d.tx   = pick_byte(q.ridx, q.rd_cmd, rd_data);
                            d.oe   = ~d.tx[7];
                            d.ridx = next_ridx(q.ridx);
                        end else begin
                            d.st = ST_WRITE;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_WRITE_ACK: begin
                    if (scl_fall) begin
                        d.oe      = 1'b0;
                        d.st      = ST_WRITE;
                        d.bit_cnt = '0;
                    end
                end
                ST_READ: begin
                    if (scl_rise && !q.byte_done) begin
                        d.bit_cnt = q.bit_cnt + 1'b1;
                        if (q.bit_cnt == BIT_LAST) d.byte_done = 1'b1;
                    end else if (scl_fall) begin
                        if (q.byte_done) begin
                            d.byte_done = 1'b0;
                            d.oe        = 1'b0;
                            d.st        = ST_READ_ACK;
                        end else begin
                            d.tx = {q.tx[6:0], 1'b1};
                            d.oe = ~q.tx[6];
                        end
                    end
                end
                ST_READ_ACK: begin
                    if (scl_rise) begin
                        if (sda_s) d.st = ST_SKIP;
                        else       d.byte_done = 1'b1;
                    end else if (scl_fall && q.byte_done) begin
                        d.byte_done = 1'b0;
                        d.bit_cnt   = '0;
                        d.st        = ST_READ;
                        d.tx        = pick_byte(q.ridx, q.rd_cmd, rd_data);
                        d.oe        = ~d.tx[7];
                        d.ridx      = next_ridx(q.ridx);
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.tx    <= '1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign wr_en   = q.wen;
    assign wr_cmd  = q.wcmd;
    assign wr_data = q.wdata;
    assign rd_chan = q.rd_cmd[CHAN_W-1:0];

endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target #(
    parameter int         SYNC_STAGES = 2,
    parameter int         CHAN_W      = 4,
    parameter logic [4:0] ADDR_PREFIX = 5'b00011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        strap_i,
    output logic              wr_en,
    output logic [7:0]        wr_cmd,
    output logic [15:0]       wr_data,
    output logic [CHAN_W-1:0] rd_chan,
    input  logic [15:0]       rd_data
);

    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic start_det;
    logic stop_det;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_frame_ctrl #(
        .ADDR_PREFIX (ADDR_PREFIX),
        .CHAN_W      (CHAN_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap_i   (strap_i),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_cmd    (wr_cmd),
        .wr_data   (wr_data),
        .rd_chan   (rd_chan)
    );

endmodule

// File: rtl/i2c_cmd_target_chk.sv
module i2c_cmd_target_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_oe,
    input logic        wr_en,
    input logic [7:0]  wr_cmd,
    input logic [15:0] wr_data,
    input logic        start_det,
    input logic        stop_det
);

    AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R3

    AST_WR_DURING_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_oe); // R3

    AST_WR_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({wr_cmd, wr_data}) |-> wr_en); // R3

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_i)); // R10

    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe); // R9

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R9

endmodule

bind i2c_cmd_target i2c_cmd_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_cmd    (wr_cmd),
    .wr_data   (wr_data),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/i2c_cmd_target_tb.sv
module i2c_cmd_target_tb;

    localparam int QTR = 20;
    localparam logic [1:0] STRAP = 2'b10;
    localparam logic [7:0] AW = {5'b00011, STRAP, 1'b0};
    localparam logic [7:0] AR = {5'b00011, STRAP, 1'b1};
    localparam logic [7:0] ABAD = {5'b00011, 2'b11, 1'b0};
    localparam int NVEC = 6;
    localparam logic [23:0] WR_VEC [NVEC] = '{
        24'h03ABCD, 24'h0F1234, 24'h00FFFF, 24'h0A0001, 24'h30BEEF, 24'hF5A55A
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_bus;
    logic        sda_oe;
    logic        wr_en;
    logic [7:0]  wr_cmd;
    logic [15:0] wr_data;
    logic [3:0]  rd_chan;
    logic [15:0] rd_data;

    logic [15:0] regs [16];
    int          wr_cnt;
    logic [7:0]  last_cmd;
    logic [15:0] last_data;
    int          total = 0;
    int          bad = 0;
    int          r10_viol = 0;
    bit          done = 1'b0;
    logic        oe_prev = 1'b0;
    logic        scl_prev = 1'b1;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;
    assign rd_data = regs[rd_chan];

    i2c_cmd_target u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_bus),
        .sda_oe  (sda_oe),
        .strap_i (STRAP),
        .wr_en   (wr_en),
        .wr_cmd  (wr_cmd),
        .wr_data (wr_data),
        .rd_chan (rd_chan),
        .rd_data (rd_data)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) regs[i] <= 16'h0;
            wr_cnt    <= 0;
            last_cmd  <= 8'h0;
            last_data <= 16'h0;
        end else if (wr_en) begin
            wr_cnt    <= wr_cnt + 1;
            last_cmd  <= wr_cmd;
            last_data <= wr_data;
            if (wr_cmd[7:4] == 4'h0) regs[wr_cmd[3:0]] <= wr_data;
        end
    end

    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev && scl_prev && scl_m) r10_viol++;
        oe_prev  <= sda_oe;
        scl_prev <= scl_m;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic clk_bit(input logic v, output logic s);
        sda_m = v;
        wq();
        scl_m = 1'b1;
        wq();
        s = sda_bus;
        wq();
        scl_m = 1'b0;
        wq();
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wq();
        scl_m = 1'b1;
        wq();
        sda_m = 1'b0;
        wq();
        scl_m = 1'b0;
        wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wq();
        scl_m = 1'b1;
        wq();
        sda_m = 1'b1;
        wq();
        wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic master_ack, output logic [7:0] b);
        logic s;
        b = 8'h0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            b = {b[6:0], s};
        end
        clk_bit(~master_ack, s);
    endtask

    task automatic readback(input logic [7:0] cmd, input int nbytes, input string req,
                            input logic [7:0] e0, input logic [7:0] e1,
                            input logic [7:0] e2, input logic [7:0] e3);
        logic ack;
        logic [7:0] b;
        logic [7:0] exp [4];
        exp = '{e0, e1, e2, e3};
        bus_start();
        send_byte(AW, ack);
        send_byte(cmd, ack);
        bus_start();
        send_byte(AR, ack);
        chk("R1 read address ack", {31'd0, ack}, 32'd1);
        for (int i = 0; i < nbytes; i++) begin
            read_byte(i != nbytes - 1, b);
            chk(req, {24'd0, b}, {24'd0, exp[i]});
        end
        bus_stop();
    endtask

    initial begin
        logic ack;
        int   base;
        logic [7:0] b;
        repeat (5) @(negedge clk);
        chk("R11 sda_oe after reset", {31'd0, sda_oe}, 32'd0);
        chk("R11 wr_en after reset", {31'd0, wr_en}, 32'd0);
        chk("R11 wr_cmd/wr_data after reset", {8'd0, wr_cmd, wr_data}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Table walk: one complete word per frame (R1, R2, R3)
        for (int v = 0; v < NVEC; v++) begin
            base = wr_cnt;
            bus_start();
            send_byte(AW, ack);
            chk("R1 address ack", {31'd0, ack}, 32'd1);
            for (int k = 2; k >= 0; k--) begin
                send_byte(WR_VEC[v][k*8 +: 8], ack);
                chk("R2 byte ack", {31'd0, ack}, 32'd1);
            end
            chk("R3 single strobe", wr_cnt - base, 32'd1);
            chk("R3 command", {24'd0, last_cmd}, {24'd0, WR_VEC[v][23:16]});
            chk("R3 data", {16'd0, last_data}, {16'd0, WR_VEC[v][15:0]});
            bus_stop();
        end

        // R4: three words in one frame
        base = wr_cnt;
        bus_start();
        send_byte(AW, ack);
        send_byte(8'h05, ack); send_byte(8'h11, ack); send_byte(8'h11, ack);
        chk("R4 first word executes", wr_cnt - base, 32'd1);
        send_byte(8'h06, ack); send_byte(8'h22, ack); send_byte(8'h22, ack);
        send_byte(8'h07, ack); send_byte(8'h33, ack); send_byte(8'h33, ack);
        bus_stop();
        chk("R4 three strobes", wr_cnt - base, 32'd3);
        chk("R4 last word", {8'd0, last_cmd, last_data}, 32'h00073333);
        chk("R4 middle word stored", {16'd0, regs[6]}, 32'h2222);

        // R5: partial word discarded at STOP
        base = wr_cnt;
        bus_start();
        send_byte(AW, ack);
        send_byte(8'h08, ack); send_byte(8'h44, ack);
        bus_stop();
        chk("R5 partial word no strobe", wr_cnt - base, 32'd0);
        chk("R5 outputs unchanged", {8'd0, wr_cmd, wr_data}, 32'h00073333);

        // R1: wrong strap address ignored
        base = wr_cnt;
        bus_start();
        send_byte(ABAD, ack);
        chk("R1 mismatch no ack", {31'd0, ack}, 32'd0);
        send_byte(8'h09, ack);
        chk("R1 mismatch byte no ack", {31'd0, ack}, 32'd0);
        send_byte(8'h55, ack); send_byte(8'h66, ack);
        bus_stop();
        chk("R1 mismatch no strobe", wr_cnt - base, 32'd0);

        // R9: repeated START in the middle of a byte
        base = wr_cnt;
        bus_start();
        send_byte(AW, ack);
        send_byte(8'h0B, ack);
        clk_bit(1'b0, b[0]); clk_bit(1'b1, b[0]); clk_bit(1'b1, b[0]);
        bus_start();
        send_byte(AW, ack);
        chk("R9 address ack after restart", {31'd0, ack}, 32'd1);
        send_byte(8'h0C, ack); send_byte(8'h77, ack); send_byte(8'h88, ack);
        bus_stop();
        chk("R9 one strobe after restart", wr_cnt - base, 32'd1);
        chk("R9 restarted word", {8'd0, last_cmd, last_data}, 32'h000C7788);

        // R6/R7: readback of code register 3 (0xABCD), then padding
        readback(8'h03, 4, "R6 R7 readback 0x03", 8'hAB, 8'hCD, 8'hFF, 8'hFF);
        chk("R6 rd_chan", {28'd0, rd_chan}, 32'd3);
        readback(8'h05, 2, "R6 readback 0x05", 8'h11, 8'h11, 8'hFF, 8'hFF);
        // R7: non-code command reads all ones
        readback(8'h3A, 3, "R7 non-code readback", 8'hFF, 8'hFF, 8'hFF, 8'hFF);

        // R8: NACK after first byte releases SDA (reg 0x0A = 0x0001)
        bus_start();
        send_byte(AW, ack);
        send_byte(8'h0A, ack);
        bus_start();
        send_byte(AR, ack);
        read_byte(1'b0, b);
        chk("R8 high byte", {24'd0, b}, 32'h00);
        chk("R8 released after NACK", {31'd0, sda_oe}, 32'd0);
        read_byte(1'b0, b);
        chk("R8 no drive after NACK", {24'd0, b}, 32'hFF);
        bus_stop();

        chk("R10 sda_oe changes only with SCL low", r10_viol, 32'd0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule